// File: doc/BRIEF.md
# Deferred Target Policy Update Controller

This block keeps the acceptance policy of a two-wire bus target in two copies. Firmware writes a staging copy through a small register port and, in the same write, raises an update request. The copy that the target logic actually uses is refreshed from the staging copy only while the bus is idle. The request flag is then dropped, so a policy change never lands in the middle of a transaction. Firmware polls the flag and treats zero as proof that the written policy is now live.

A bus-state tracker follows start and stop conditions through address, command and data bytes. For every byte it emits a registered ACK or NACK decision. The live policy can refuse a transaction at its address byte, either because the whole target is off or because the matched address is off. It can also let the address through and refuse the command byte. Once a byte is refused, the rest of the transaction is ignored.

Top module: `tgt_policy_ctrl`

## Requirements
- R1: After reset the register reads 0, the update request is clear and the live policy has the target disabled, so every address byte is answered with NACK.
- R2: The register read value is {request (bit 4), command-refuse (bit 3), address-1 enable (bit 2), address-0 enable (bit 1), target enable (bit 0)} from the staging copy. It reflects a write on the cycle after that write.
- R3: With the bus idle and the request set, the live policy takes the staging value on the next clock and the request reads 0 from then on.
- R4: While the bus is busy (from a start until a stop), the request stays set and transactions keep using the old live policy. The load happens on the first idle cycle after the stop.
- R5: With target enable 0 in the live policy, an address byte that matches any configured address is answered with NACK.
- R6: An address byte whose upper seven bits match configured address i (default 0x21 for i=0, 0x52 for i=1) is answered with ACK only when target enable and that address's enable are both 1.
- R7: An address byte that matches no configured address is answered with NACK.
- R8: With command-refuse 1, an accepted address byte is followed by a NACK on the command byte.
- R9: After an accepted command byte, data bytes are answered with ACK. After any NACK, no further responses are given until the next start.
- R10: A second write while a request is pending replaces the staging value, and only the latest value becomes live.
- R11: A write with the request bit 0 updates the staging copy only. The live policy stays unchanged across later idle periods.
- R12: A start seen while busy (repeated start) returns the tracker to the address phase, even after a NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Policy register write strobe |
| cfg_wdata | input | 5 | Write data: policy fields plus request bit |
| cfg_rdata | output | 5 | Staging policy and request flag |
| bus_start | input | 1 | Start condition pulse |
| bus_stop | input | 1 | Stop condition pulse |
| bus_byte_vld | input | 1 | A received byte is present |
| bus_byte | input | 8 | Received byte; address in bits 7:1 |
| resp_vld | output | 1 | A response is given for the last byte |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK |

## Verification
The bench builds the block with its defaults: two target addresses, 0x21 and 0x52, seven address bits, and a five-bit register. Two addresses are enough to disable one while the other still answers, and an unused address such as 0x33 shows the no-match path. Writes are placed both in idle gaps and inside open transactions, including back-to-back writes and repeated starts. This makes it possible to observe deferred loading, replacement of a pending value and use of the old policy mid-transaction.

// File: rtl/tgt_policy_pkg.sv
package tgt_policy_pkg;
    parameter int unsigned TP_NUM_ADDR = 2;
    parameter int unsigned TP_ADDR_W   = 7;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_CMD  = 3'd2,
        PH_DATA = 3'd3,
        PH_IGN  = 3'd4
    } phase_e;
endpackage

// File: rtl/tgt_policy_regs.sv
module tgt_policy_regs #(
    parameter int unsigned NUM_ADDR = tgt_policy_pkg::TP_NUM_ADDR,
    localparam int unsigned POL_W   = NUM_ADDR + 2,
    localparam int unsigned REG_W   = POL_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             bus_idle,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [POL_W-1:0] act_pol
);
    typedef struct packed {
        logic [POL_W-1:0] wr;
        logic             req;
        logic [POL_W-1:0] act;
    } regs_t;

    regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (cfg_we) begin
            nxt_d.wr  = cfg_wdata[POL_W-1:0];
            nxt_d.req = cfg_wdata[POL_W];
        end else if (bus_idle && cur_q.req) begin
            nxt_d.act = cur_q.wr;
            nxt_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cfg_rdata = {cur_q.req, cur_q.wr};
    assign act_pol   = cur_q.act;

    // R4
    act_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.act) |-> $past(bus_idle && cur_q.req));

    // R3
    act_load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cur_q.req) && !$past(cfg_we)) |-> (cur_q.act == $past(cur_q.wr)));

    // R4
    req_clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cur_q.req) && !$past(cfg_we)) |-> $past(bus_idle));
endmodule

// File: rtl/tgt_ack_decide.sv
module tgt_ack_decide #(
    parameter int unsigned NUM_ADDR = tgt_policy_pkg::TP_NUM_ADDR,
    parameter int unsigned ADDR_W   = tgt_policy_pkg::TP_ADDR_W,
    parameter logic [NUM_ADDR*ADDR_W-1:0] TGT_ADDRS = {7'h52, 7'h21},
    localparam int unsigned POL_W   = NUM_ADDR + 2
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [POL_W-1:0]  act_pol,
    output logic              addr_ok,
    output logic              cmd_ok
);
    logic [NUM_ADDR-1:0] hit_en;

    for (genvar i = 0; i < NUM_ADDR; i++) begin : g_match
        assign hit_en[i] = (addr_in == TGT_ADDRS[i*ADDR_W +: ADDR_W]) && act_pol[1+i];
    end

    assign addr_ok = act_pol[0] && (|hit_en);
    assign cmd_ok  = !act_pol[POL_W-1];
endmodule

// File: rtl/tgt_bus_tracker.sv
module tgt_bus_tracker
    import tgt_policy_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bus_start,
    input  logic   bus_stop,
    input  logic   bus_byte_vld,
    input  logic   addr_ok,
    input  logic   cmd_ok,
    output phase_e phase,
    output logic   bus_idle,
    output logic   resp_vld,
    output logic   resp_ack
);
    typedef struct packed {
        phase_e ph;
        logic   vld;
        logic   ack;
    } trk_t;

    trk_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        nxt_d.ack = 1'b0;
        if (bus_stop) begin
            nxt_d.ph = PH_IDLE;
        end else if (bus_start) begin
            nxt_d.ph = PH_ADDR;
        end else if (bus_byte_vld) begin
            case (cur_q.ph)
                PH_ADDR: begin
                    nxt_d.vld = 1'b1;
                    nxt_d.ack = addr_ok;
                    nxt_d.ph  = addr_ok ? PH_CMD : PH_IGN;
                end
                PH_CMD: begin
                    nxt_d.vld = 1'b1;
                    nxt_d.ack = cmd_ok;
                    nxt_d.ph  = cmd_ok ? PH_DATA : PH_IGN;
                end
                PH_DATA: begin
                    nxt_d.vld = 1'b1;
                    nxt_d.ack = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ph: PH_IDLE, vld: 1'b0, ack: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign phase    = cur_q.ph;
    assign bus_idle = (cur_q.ph == PH_IDLE);
    assign resp_vld = cur_q.vld;
    assign resp_ack = cur_q.ack;

    // R9
    ign_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == PH_IGN && !bus_start) |=> !cur_q.vld);

    // R12
    restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !bus_stop) |=> (cur_q.ph == PH_ADDR));

    // R1
    resp_busy_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.vld |-> $past(cur_q.ph != PH_IDLE));
endmodule

// File: rtl/tgt_policy_ctrl.sv
module tgt_policy_ctrl
    import tgt_policy_pkg::*;
#(
    parameter int unsigned NUM_ADDR = TP_NUM_ADDR,
    parameter int unsigned ADDR_W   = TP_ADDR_W,
    parameter logic [NUM_ADDR*ADDR_W-1:0] TGT_ADDRS = {7'h52, 7'h21},
    localparam int unsigned POL_W   = NUM_ADDR + 2,
    localparam int unsigned REG_W   = POL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              bus_byte_vld,
    input  logic [ADDR_W:0]   bus_byte,
    output logic              resp_vld,
    output logic              resp_ack
);
    logic [POL_W-1:0] act_pol;
    logic             bus_idle;
    logic             addr_ok;
    logic             cmd_ok;
    phase_e           phase;
    logic             unused_rw_bit;

    assign unused_rw_bit = bus_byte[0];

    tgt_policy_regs #(.NUM_ADDR(NUM_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_idle(bus_idle), .cfg_rdata(cfg_rdata), .act_pol(act_pol)
    );

    tgt_ack_decide #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W), .TGT_ADDRS(TGT_ADDRS)) u_decide (
        .addr_in(bus_byte[ADDR_W:1]), .act_pol(act_pol),
        .addr_ok(addr_ok), .cmd_ok(cmd_ok)
    );

    tgt_bus_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_byte_vld(bus_byte_vld), .addr_ok(addr_ok), .cmd_ok(cmd_ok),
        .phase(phase), .bus_idle(bus_idle), .resp_vld(resp_vld), .resp_ack(resp_ack)
    );

    // R5
    tgt_off_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && $past(phase == PH_ADDR) && !$past(act_pol[0])) |-> !resp_ack);

    // R8
    cmd_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_vld && $past(phase == PH_CMD) && $past(act_pol[POL_W-1])) |-> !resp_ack);
endmodule

// File: tb/tgt_policy_ctrl_bench.sv
`timescale 1ns/1ps
module tgt_policy_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = '0;
    logic [4:0] cfg_rdata;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       bus_byte_vld = 1'b0;
    logic [7:0] bus_byte = '0;
    logic       resp_vld;
    logic       resp_ack;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        bit    ack;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    tgt_policy_ctrl u_tgt_policy_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_start(bus_start), .bus_stop(bus_stop),
        .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte),
        .resp_vld(resp_vld), .resp_ack(resp_ack)
    );

    // monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && resp_vld) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R9: unexpected response ack=%0d, expected none", resp_ack);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (resp_ack !== e.ack) begin
                    n_fail++;
                    $display("FAIL %s: ack=%0d expected %0d", e.tag, resp_ack, e.ack);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [4:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic check_rd(input logic [4:0] exp, input string tag);
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%h expected %h", tag, cfg_rdata, exp);
        end
    endtask

    task automatic do_start();
        bus_start = 1'b1; tick(); bus_start = 1'b0;
    endtask

    task automatic do_stop();
        bus_stop = 1'b1; tick(); bus_stop = 1'b0;
    endtask

    // driver: pushes the expected item, then presents the byte
    task automatic send(input logic [7:0] b, input bit present, input bit ack, input string tag);
        if (present) begin
            exp_t e;
            e.ack = ack; e.tag = tag;
            exp_q.push_back(e);
        end
        bus_byte_vld = 1'b1; bus_byte = b;
        tick();
        bus_byte_vld = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check_rd(5'h00, "R1");
        do_start(); send(8'h42, 1, 0, "R1"); do_stop();

        cfg_write(5'h17);
        check_rd(5'h17, "R2");
        tick();
        check_rd(5'h07, "R3");
        do_start(); send(8'h42, 1, 1, "R3"); send(8'hA5, 1, 1, "R9"); send(8'h11, 1, 1, "R9"); do_stop();
        do_start(); send(8'hA4, 1, 1, "R6"); do_stop();
        do_start(); send(8'h66, 1, 0, "R7"); send(8'h11, 0, 0, "R9"); do_stop();

        do_start(); send(8'h42, 1, 1, "R4");
        cfg_write(5'h15);
        tick();
        check_rd(5'h15, "R4");
        send(8'h01, 1, 1, "R4");
        do_start(); send(8'h42, 1, 1, "R4"); do_stop();
        tick();
        check_rd(5'h05, "R4");
        do_start(); send(8'h42, 1, 0, "R6"); do_stop();
        do_start(); send(8'hA4, 1, 1, "R6"); do_stop();

        do_start();
        cfg_write(5'h1F);
        cfg_write(5'h16);
        do_stop();
        tick();
        check_rd(5'h06, "R10");
        do_start(); send(8'hA4, 1, 0, "R5"); do_stop();
        do_start(); send(8'h42, 1, 0, "R10"); do_stop();

        cfg_write(5'h1F);
        tick();
        check_rd(5'h0F, "R8");
        do_start(); send(8'h42, 1, 1, "R8"); send(8'h07, 1, 0, "R8"); send(8'h33, 0, 0, "R9"); do_stop();

        cfg_write(5'h07);
        check_rd(5'h07, "R11");
        tick(); tick();
        check_rd(5'h07, "R11");
        do_start(); send(8'h42, 1, 1, "R11"); send(8'h07, 1, 0, "R11"); do_stop();
        tick();
        do_start(); send(8'hA4, 1, 1, "R11"); send(8'h08, 1, 0, "R11"); do_stop();

        do_start(); send(8'h66, 1, 0, "R12");
        do_start(); send(8'h42, 1, 1, "R12"); do_stop();

        repeat (4) tick();
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9: %0d responses missing, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule